// File: doc/BRIEF.md
# OTP Key Row Fetch Sequencer

This block gathers a cryptographic key out of one-time-programmable storage, one 32-bit word per row. After a start pulse it walks upward from a first row, reading rows one at a time through a request/acknowledge interface. Each response carries 32 data bits and a single flag that marks the row as bad: an uncorrectable ECC error or a failure indication. Bad rows are stepped over and contribute nothing. Every good word is handed out on a word stream with a one-cycle strobe and its position in the key.

Collection ends when the requested number of words has been gathered or the row pointer has moved beyond the last permitted row. The block then raises a done flag together with a verdict. The key is rejected if every collected word ANDs to all ones, if every collected word ORs to zero, or if the row pointer ended past the last row. Done and the verdict stay stable until the next start. A start pulse that arrives during a fetch is disregarded.

Top module: `otp_keyfetch`

## Requirements
- R1: Out of reset, `done_o`, `fail_o`, `rd_req_o` and `key_vld_o` are all low.
- R2: Rows are requested one at a time, starting at `row_first_i` and rising by one after every acknowledge (good or bad); `rd_req_o` and `rd_row_o` hold steady until `rd_ack_i` is seen high in a cycle where `rd_req_o` is high.
- R3: A row acknowledged with `rd_err_i` high produces no word strobe and does not count toward the word total.
- R4: A row acknowledged with `rd_err_i` low produces, in the next cycle, a one-cycle `key_vld_o` with the row's data on `key_word_o` and a zero-based index on `key_idx_o` that rises by one per accepted word.
- R5: Once `word_cnt_i` words have been accepted, no further row is requested and `done_o` rises; a word count of zero requests no row at all.
- R6: The verdict is fail when the bitwise AND of all accepted words equals all ones (this includes the case of no accepted word).
- R7: The verdict is fail when the bitwise OR of all accepted words equals zero.
- R8: The verdict is fail when the row pointer has passed `row_last_i` at the moment collection stops; this includes a fetch whose final word came from the last row, and a start with `row_first_i` above `row_last_i`, which requests nothing.
- R9: `done_o` and `fail_o` keep their values until the next start; the cycle after an accepted start `done_o` is low.
- R10: A start pulse while a fetch is in progress has no effect on the rows requested, the words emitted or the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fetch (honoured only when idle or done) |
| word_cnt_i | input | CNT_W | Number of key words to gather, sampled at start |
| row_first_i | input | ROW_W | First row to read, sampled at start |
| row_last_i | input | ROW_W | Last row that may be read, sampled at start |
| rd_req_o | output | 1 | Row read request, held until acknowledged |
| rd_row_o | output | ROW_W | Row being requested |
| rd_ack_i | input | 1 | Row read response valid |
| rd_data_i | input | DATA_W | Row data returned with the acknowledge |
| rd_err_i | input | 1 | Row is bad (ECC error or failure flag) |
| key_vld_o | output | 1 | One-cycle strobe for an accepted key word |
| key_word_o | output | DATA_W | Accepted key word |
| key_idx_o | output | CNT_W | Position of the word in the key, from zero |
| done_o | output | 1 | Fetch finished; held until next start |
| fail_o | output | 1 | Verdict, valid while done_o is high |

## Verification
The properties assume the row source only raises `rd_ack_i` in a cycle where `rd_req_o` is high, with `rd_data_i` and `rd_err_i` valid in that same cycle, and that `start_i` is a pulse. The bench's behavioural row source waits for a request at the falling edge, holds off a row-dependent number of cycles, then acknowledges for exactly one cycle and lowers the acknowledge again, so it never answers without an open request. Start is driven for a single cycle, including the deliberate pulse issued while a request is open.

// File: rtl/keyfetch_pkg.sv
package keyfetch_pkg;

    typedef enum logic [1:0] {
        KF_IDLE = 2'd0,
        KF_EVAL = 2'd1,
        KF_READ = 2'd2,
        KF_DONE = 2'd3
    } kf_state_e;

endpackage

// File: rtl/keyfetch_accum.sv
module keyfetch_accum #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [CNT_W-1:0]  idx_i,
    output logic              key_vld_o,
    output logic [DATA_W-1:0] key_word_o,
    output logic [CNT_W-1:0]  key_idx_o,
    output logic              all_ones_o,
    output logic              all_zero_o
);

    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    typedef struct packed {
        logic [DATA_W-1:0] or_v;
        logic [DATA_W-1:0] and_v;
        logic              vld;
        logic [DATA_W-1:0] word;
        logic [CNT_W-1:0]  idx;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d     = acc_q;
        acc_d.vld = 1'b0;
        if (clr_i) begin
            acc_d.or_v  = '0;
            acc_d.and_v = ONES;
        end else if (take_i) begin
            acc_d.or_v  = acc_q.or_v | word_i;
            acc_d.and_v = acc_q.and_v & word_i;
            acc_d.vld   = 1'b1;
            acc_d.word  = word_i;
            acc_d.idx   = idx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.or_v  <= '0;
            acc_q.and_v <= ONES;
            acc_q.vld   <= 1'b0;
            acc_q.word  <= '0;
            acc_q.idx   <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign key_vld_o  = acc_q.vld;
    assign key_word_o = acc_q.word;
    assign key_idx_o  = acc_q.idx;
    assign all_ones_o = (acc_q.and_v == ONES);
    assign all_zero_o = (acc_q.or_v == '0);

endmodule

// File: rtl/keyfetch_seq.sv
module keyfetch_seq
    import keyfetch_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] word_cnt_i,
    input  logic [ROW_W-1:0] row_first_i,
    input  logic [ROW_W-1:0] row_last_i,
    output logic             rd_req_o,
    output logic [ROW_W-1:0] rd_row_o,
    input  logic             rd_ack_i,
    input  logic             rd_err_i,
    output logic             acc_clr_o,
    output logic             acc_take_o,
    output logic [CNT_W-1:0] got_o,
    input  logic             all_ones_i,
    input  logic             all_zero_i,
    output logic             done_o,
    output logic             fail_o
);

    // one spare bit so the pointer can step past the top row without wrapping
    localparam int PTR_W = ROW_W + 1;

    typedef struct packed {
        kf_state_e        state;
        logic [PTR_W-1:0] row;
        logic [PTR_W-1:0] last;
        logic [CNT_W-1:0] need;
        logic [CNT_W-1:0] got;
        logic             fail;
    } seq_t;

    seq_t seq_d, seq_q;
    logic past_end;
    logic enough;

    assign past_end = (seq_q.row > seq_q.last);
    assign enough   = (seq_q.got == seq_q.need);

    always_comb begin
        seq_d      = seq_q;
        acc_clr_o  = 1'b0;
        acc_take_o = 1'b0;
        case (seq_q.state)
            KF_IDLE, KF_DONE: begin
                if (start_i) begin
                    seq_d.state = KF_EVAL;
                    seq_d.row   = {1'b0, row_first_i};
                    seq_d.last  = {1'b0, row_last_i};
                    seq_d.need  = word_cnt_i;
                    seq_d.got   = '0;
                    seq_d.fail  = 1'b0;
                    acc_clr_o   = 1'b1;
                end
            end
            KF_EVAL: begin
                if (enough || past_end) begin
                    seq_d.state = KF_DONE;
                    seq_d.fail  = past_end | all_ones_i | all_zero_i;
                end else begin
                    seq_d.state = KF_READ;
                end
            end
            KF_READ: begin
                if (rd_ack_i) begin
                    seq_d.state = KF_EVAL;
                    seq_d.row   = seq_q.row + PTR_W'(1);
                    if (!rd_err_i) begin
                        seq_d.got  = seq_q.got + CNT_W'(1);
                        acc_take_o = 1'b1;
                    end
                end
            end
            default: seq_d.state = KF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= KF_IDLE;
            seq_q.row   <= '0;
            seq_q.last  <= '0;
            seq_q.need  <= '0;
            seq_q.got   <= '0;
            seq_q.fail  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_req_o = (seq_q.state == KF_READ);
    assign rd_row_o = seq_q.row[ROW_W-1:0];
    assign got_o    = seq_q.got;
    assign done_o   = (seq_q.state == KF_DONE);
    assign fail_o   = seq_q.fail;

endmodule

// File: rtl/otp_keyfetch.sv
module otp_keyfetch #(
    parameter int ROW_W  = 10,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    input  logic [ROW_W-1:0]  row_first_i,
    input  logic [ROW_W-1:0]  row_last_i,
    output logic              rd_req_o,
    output logic [ROW_W-1:0]  rd_row_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_err_i,
    output logic              key_vld_o,
    output logic [DATA_W-1:0] key_word_o,
    output logic [CNT_W-1:0]  key_idx_o,
    output logic              done_o,
    output logic              fail_o
);

    logic             acc_clr;
    logic             acc_take;
    logic [CNT_W-1:0] got;
    logic             all_ones;
    logic             all_zero;

    keyfetch_seq #(
        .ROW_W (ROW_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .word_cnt_i  (word_cnt_i),
        .row_first_i (row_first_i),
        .row_last_i  (row_last_i),
        .rd_req_o    (rd_req_o),
        .rd_row_o    (rd_row_o),
        .rd_ack_i    (rd_ack_i),
        .rd_err_i    (rd_err_i),
        .acc_clr_o   (acc_clr),
        .acc_take_o  (acc_take),
        .got_o       (got),
        .all_ones_i  (all_ones),
        .all_zero_i  (all_zero),
        .done_o      (done_o),
        .fail_o      (fail_o)
    );

    keyfetch_accum #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (acc_clr),
        .take_i     (acc_take),
        .word_i     (rd_data_i),
        .idx_i      (got),
        .key_vld_o  (key_vld_o),
        .key_word_o (key_word_o),
        .key_idx_o  (key_idx_o),
        .all_ones_o (all_ones),
        .all_zero_o (all_zero)
    );

endmodule

// File: rtl/keyfetch_chk.sv
module keyfetch_chk #(
    parameter int ROW_W  = 10,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic [ROW_W-1:0]  rd_row_o,
    input logic              rd_ack_i,
    input logic              rd_err_i,
    input logic              key_vld_o,
    input logic [CNT_W-1:0]  key_idx_o,
    input logic              done_o,
    input logic              fail_o
);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_row_o)));

    p_req_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i) |=> !rd_req_o);

    p_err_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && rd_err_i) |=> !key_vld_o);

    p_vld_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld_o |-> $past(rd_req_o && rd_ack_i && !rd_err_i));

    p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld_o |=> !key_vld_o);

    p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!rd_req_o && !key_vld_o));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(fail_o)));

    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !done_o);

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i && start_i) |=> (rd_req_o && $stable(rd_row_o)));

endmodule

bind otp_keyfetch keyfetch_chk #(
    .ROW_W  (ROW_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_row_o  (rd_row_o),
    .rd_ack_i  (rd_ack_i),
    .rd_err_i  (rd_err_i),
    .key_vld_o (key_vld_o),
    .key_idx_o (key_idx_o),
    .done_o    (done_o),
    .fail_o    (fail_o)
);

// File: tb/sim_otp_keyfetch.sv
`timescale 1ns/1ps
module sim_otp_keyfetch;

    localparam int ROW_W  = 10;
    localparam int CNT_W  = 4;
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  word_cnt_i = '0;
    logic [ROW_W-1:0]  row_first_i = '0;
    logic [ROW_W-1:0]  row_last_i = '0;
    logic              rd_req_o;
    logic [ROW_W-1:0]  rd_row_o;
    logic              rd_ack_i = 1'b0;
    logic [DATA_W-1:0] rd_data_i = '0;
    logic              rd_err_i = 1'b0;
    logic              key_vld_o;
    logic [DATA_W-1:0] key_word_o;
    logic [CNT_W-1:0]  key_idx_o;
    logic              done_o;
    logic              fail_o;

    always #10 clk = ~clk;

    otp_keyfetch #(.ROW_W(ROW_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (.*);

    int total = 0;
    int bad   = 0;
    int pmode = 0;   // 0 hashed, 1 zeros, 2 ones, 3 first row ones then hashed
    int emod  = 0;   // rows with row % emod == 1 are bad when emod > 0
    int base_row = 0;
    int words_seen = 0;

    logic [ROW_W-1:0]         exp_rows[$];
    logic [CNT_W+DATA_W-1:0]  exp_words[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] row_word(input int row);
        logic [DATA_W-1:0] h;
        h = DATA_W'((row + 1) * 32'h9E3779B1) ^ 32'h13572468;
        case (pmode)
            1: return '0;
            2: return ONES;
            3: return (row == base_row) ? ONES : h;
            default: return h;
        endcase
    endfunction

    function automatic bit row_bad(input int row);
        return (emod > 0) && ((row % emod) == 1);
    endfunction

    // behavioural row source; also the row-order scoreboard
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            rd_ack_i = 1'b0;
            if (rd_req_o) begin
                if (dly > 0) begin
                    dly--;
                end else begin
                    if (exp_rows.size() == 0) begin
                        chk(1'b0, "R5", "unexpected row request", 64'(rd_row_o), 64'h0);
                    end else begin
                        logic [ROW_W-1:0] er;
                        er = exp_rows.pop_front();
                        chk(rd_row_o == er, "R2", "requested row", 64'(rd_row_o), 64'(er));
                    end
                    rd_data_i = row_word(int'(rd_row_o));
                    rd_err_i  = row_bad(int'(rd_row_o));
                    rd_ack_i  = 1'b1;
                    dly = int'(rd_row_o) % 3;
                end
            end
        end
    end

    // word monitor
    initial begin
        forever begin
            @(negedge clk);
            if (key_vld_o) begin
                words_seen++;
                if (exp_words.size() == 0) begin
                    chk(1'b0, "R3", "unexpected key word", 64'(key_word_o), 64'h0);
                end else begin
                    logic [CNT_W+DATA_W-1:0] ew;
                    ew = exp_words.pop_front();
                    chk(key_word_o == ew[DATA_W-1:0], "R4", "key word",
                        64'(key_word_o), 64'(ew[DATA_W-1:0]));
                    chk(key_idx_o == ew[CNT_W+DATA_W-1:DATA_W], "R4", "key index",
                        64'(key_idx_o), 64'(ew[CNT_W+DATA_W-1:DATA_W]));
                end
            end
        end
    end

    task automatic run_fetch(input int first, input int last, input int cnt,
                             input int pm, input int em, input bit poke,
                             input string ftag);
        int row;
        int got;
        logic [DATA_W-1:0] acc_or;
        logic [DATA_W-1:0] acc_and;
        bit exp_fail;
        bit poked;
        bit finished;
        pmode = pm;
        emod = em;
        base_row = first;
        row = first;
        got = 0;
        acc_or = '0;
        acc_and = ONES;
        while (got < cnt && row <= last) begin
            exp_rows.push_back(ROW_W'(row));
            if (!row_bad(row)) begin
                logic [DATA_W-1:0] w;
                w = row_word(row);
                exp_words.push_back({CNT_W'(got), w});
                acc_or = acc_or | w;
                acc_and = acc_and & w;
                got++;
            end
            row++;
        end
        exp_fail = (acc_and == ONES) || (acc_or == '0) || (row > last);

        @(negedge clk);
        row_first_i = ROW_W'(first);
        row_last_i  = ROW_W'(last);
        word_cnt_i  = CNT_W'(cnt);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R9", "done low after start", 64'(done_o), 64'h0);

        poked = 1'b0;
        finished = 1'b0;
        for (int i = 0; i < 3000 && !finished; i++) begin
            if (poke && !poked && rd_req_o) begin
                row_first_i = ROW_W'(first + 7);
                row_last_i  = ROW_W'(first + 9);
                word_cnt_i  = CNT_W'(1);
                start_i = 1'b1;
                poked = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end else begin
                @(negedge clk);
            end
            if (done_o) finished = 1'b1;
        end
        chk(finished, "R5", "done reached", 64'(finished), 64'h1);
        chk(fail_o == exp_fail, ftag, "verdict", 64'(fail_o), 64'(exp_fail));
        chk(exp_rows.size() == 0, "R2", "rows left unrequested",
            64'(exp_rows.size()), 64'h0);
        chk(exp_words.size() == 0, "R4", "words left unseen",
            64'(exp_words.size()), 64'h0);
        if (poke) chk(poked, "R10", "busy start issued", 64'(poked), 64'h1);

        repeat (4) @(negedge clk);
        chk(done_o == 1'b1, "R9", "done held", 64'(done_o), 64'h1);
        chk(fail_o == exp_fail, "R9", "verdict held", 64'(fail_o), 64'(exp_fail));
        chk(rd_req_o == 1'b0, "R5", "no request after done", 64'(rd_req_o), 64'h0);
        exp_rows.delete();
        exp_words.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done_o && !fail_o && !rd_req_o && !key_vld_o, "R1", "outputs in reset",
            64'({done_o, fail_o, rd_req_o, key_vld_o}), 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done_o && !fail_o && !rd_req_o && !key_vld_o, "R1", "outputs idle after reset",
            64'({done_o, fail_o, rd_req_o, key_vld_o}), 64'h0);

        // R4 R5: clean rows, key fills well inside the range -> pass
        run_fetch(10, 20, 4, 0, 0, 1'b0, "R5");
        // R3: bad rows skipped, still pass
        run_fetch(30, 60, 8, 0, 4, 1'b0, "R3");
        // R3: every other row bad
        run_fetch(100, 140, 6, 0, 2, 1'b0, "R3");
        // R8: range runs out
        run_fetch(5, 7, 5, 0, 0, 1'b0, "R8");
        // R8: last word taken from the last row still fails
        run_fetch(0, 3, 4, 0, 0, 1'b0, "R8");
        // R8: first above last, nothing requested
        run_fetch(50, 40, 3, 0, 0, 1'b0, "R8");
        // R7: all-zero words
        run_fetch(200, 220, 5, 1, 0, 1'b0, "R7");
        // R6: all-ones words
        run_fetch(300, 320, 5, 2, 0, 1'b0, "R6");
        // R6: zero-length key fails, no rows read
        run_fetch(400, 420, 0, 0, 0, 1'b0, "R6");
        // R6 R7: one all-ones word mixed with others -> pass
        run_fetch(500, 520, 3, 3, 0, 1'b0, "R7");
        // R10: start pulse during busy ignored
        run_fetch(600, 640, 6, 0, 3, 1'b1, "R10");
        // top of the row space, pointer must not wrap
        run_fetch(1020, 1023, 6, 0, 0, 1'b0, "R8");
        chk(words_seen > 30, "R4", "total words seen", 64'(words_seen), 64'd31);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule